// File: doc/BRIEF.md
# GPIO Bank with Pin Interrupts

This block is a 32-pin general-purpose I/O bank. A small memory-mapped register bus reaches it, and it drives one combined interrupt line. Software sets each pin's output value and output enable. It reads back the pin levels after a two-flop synchroniser. Each pin can raise an interrupt on a rising edge, a falling edge, a high level or a low level. Interrupt events are kept in sticky status bits. The interrupt line is the OR of status ANDed with a per-pin enable mask.

Every writable register can be reached at three addresses: one replaces the whole value, one sets bits and one clears bits. Software can therefore change single pins without a read-modify-write. Status bits are cleared only by writing ones through the clear address. A pin only feeds the detector once its route bit is set. A pin can fire on both edges if software flips that pin's polarity bit after each event.

Top module: `gpio_irq_bank`

## Requirements
- R1: Register k (0..7) sits at byte offset k*0x10. Writing offset +0x0 loads the value, +0x4 ORs the data in, and +0x8 clears the bits that are set in the data. Writes to +0xC, and to any address with bit 7 set, change nothing. Reads at any of the four offsets return the register.
- R2: The register map is: 0 output data, 1 output enable, 2 pin input (read only), 3 route select, 4 interrupt enable, 5 level select, 6 polarity, 7 status. pad_out equals the output data register and pad_oe equals the output enable register, bit for bit. A pin is driven when its pad_oe bit is 1.
- R3: Register 2 returns the pin value after a two-flop synchroniser. A change on pad_in can be read after two rising clock edges. Writes to register 2 have no effect.
- R4: Each pin's trigger comes from its level bit L (register 5) and its polarity bit P (register 6): L=0,P=0 falling edge; L=1,P=0 low level; L=0,P=1 rising edge; L=1,P=1 high level.
- R5: An edge is found by comparing the synchronised pin value with a copy delayed by one cycle. The status bit is set on the third rising edge after the pin changes.
- R6: In level mode the status bit is set on every cycle in which the active level is present. If a set event and a clear hit the same bit in the same cycle, the bit stays set.
- R7: Status bits are cleared only by writing ones to offset 0x78. Plain writes (0x70) and set writes (0x74) to the status register have no effect.
- R8: A pin whose route bit (register 3) is 0 never sets its status bit, in any mode.
- R9: irq_o is high exactly when status AND interrupt enable is nonzero. Status bits are set whether or not the enable bit is set.
- R10: After reset, every register is zero, irq_o is low and no pad is driven.
- R11: Changing a pin's polarity bit changes its edge direction, so software can catch a rising edge followed by a falling edge on the same pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access select |
| bus_wr | input | 1 | Write strobe, valid with bus_sel |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data, one bit per pin |
| bus_rdata | output | 32 | Read data for the addressed register |
| pad_in | input | 32 | Pin levels from the pads |
| pad_out | output | 32 | Value driven on each pin |
| pad_oe | output | 32 | Per-pin drive enable |
| irq_o | output | 1 | Combined bank interrupt |

## Verification
On every cycle the assertions check the following:
- A set write never clears a bit, and a clear write never sets one.
- A status bit falls only after a clear write.
- A pin that was not routed never raises its status bit.
- Any detection event sets its status bit even when a clear arrives in the same cycle.
- The interrupt stays low while the enable mask is zero.

Only the bench scenarios can show the following:
- the four trigger encodings;
- the three-edge latency from pad to status;
- a level status that survives a clear while the level is still active;
- both-edge capture by flipping the polarity bit.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int unsigned NREG  = 8;
  localparam int unsigned IDX_W = 3;
  localparam int unsigned MAP_BITS = IDX_W + 4;

  typedef enum logic [IDX_W-1:0] {
    RI_DOUT  = 3'd0,
    RI_OE    = 3'd1,
    RI_PIN   = 3'd2,
    RI_ROUTE = 3'd3,
    RI_IEN   = 3'd4,
    RI_LVL   = 3'd5,
    RI_POL   = 3'd6,
    RI_STAT  = 3'd7
  } reg_idx_e;

  typedef enum logic [1:0] {
    AL_LOAD = 2'd0,
    AL_SET  = 2'd1,
    AL_CLR  = 2'd2,
    AL_NONE = 2'd3
  } alias_e;

  typedef struct packed {
    logic load;
    logic set;
    logic clr;
  } wr_op_t;
endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw_i,
  output logic [W-1:0] cur_o,
  output logic [W-1:0] prev_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] cur_q;
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      cur_q  <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= raw_i;
      cur_q  <= meta_q;
      prev_q <= cur_q;
    end
  end

  assign cur_o  = cur_q;
  assign prev_o = prev_q;
endmodule

// File: rtl/gpio_alias_reg.sv
module gpio_alias_reg #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_load,
  input  logic         wr_set,
  input  logic         wr_clr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  logic [W-1:0] q_r;
  logic [W-1:0] q_d;
  logic         upd;

  always_comb begin
    q_d = q_r;
    upd = wr_load | wr_set | wr_clr;
    if (wr_load)     q_d = wdata;
    else if (wr_set) q_d = q_r | wdata;
    else if (wr_clr) q_d = q_r & ~wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q_r <= '0;
    else if (upd) q_r <= q_d;
  end

  assign q = q_r;

  // R1
  set_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_set |=> ((q & $past(q)) == $past(q)));

  // R1
  clr_never_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr |=> ((q & ~$past(q)) == '0));
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cur_i,
  input  logic [W-1:0] prev_i,
  input  logic [W-1:0] route_i,
  input  logic [W-1:0] lvl_i,
  input  logic [W-1:0] pol_i,
  input  logic         clr_wr_i,
  input  logic [W-1:0] clr_mask_i,
  output logic [W-1:0] stat_o
);
  logic [W-1:0] evt;
  logic [W-1:0] stat_q;
  logic [W-1:0] stat_d;
  logic [W-1:0] clr_vec;

  for (genvar g = 0; g < W; g++) begin : g_pin
    logic rise, fall, hit;
    always_comb begin
      rise = cur_i[g] & ~prev_i[g];
      fall = ~cur_i[g] & prev_i[g];
      case ({lvl_i[g], pol_i[g]})
        2'b00:   hit = fall;
        2'b01:   hit = rise;
        2'b10:   hit = ~cur_i[g];
        default: hit = cur_i[g];
      endcase
      evt[g] = route_i[g] & hit;
    end
  end

  always_comb begin
    clr_vec = clr_wr_i ? clr_mask_i : '0;
    stat_d  = (stat_q & ~clr_vec) | evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_d;
  end

  assign stat_o = stat_q;

  // R6
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |=> ((stat_q & $past(evt)) == $past(evt)));

  // R8
  unrouted_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_q & ~$past(stat_q) & ~$past(route_i)) == '0));

  // R7
  clear_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(stat_q) & ~stat_q)) |-> $past(clr_wr_i));
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_bank_pkg::*;
#(
  parameter int unsigned PINS   = 32,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [PINS-1:0]   bus_wdata,
  output logic [PINS-1:0]   bus_rdata,
  input  logic [PINS-1:0]   pad_in,
  output logic [PINS-1:0]   pad_out,
  output logic [PINS-1:0]   pad_oe,
  output logic              irq_o
);
  localparam int unsigned HI_W = ADDR_W - MAP_BITS;

  logic [IDX_W-1:0] idx;
  alias_e           al;
  logic             in_map;
  wr_op_t           ops  [NREG];
  logic [PINS-1:0]  regs [NREG];
  logic [PINS-1:0]  pin_cur;
  logic [PINS-1:0]  pin_prev;
  logic [PINS-1:0]  stat;

  always_comb begin
    idx    = bus_addr[MAP_BITS-1:4];
    al     = alias_e'(bus_addr[3:2]);
    in_map = (bus_addr[ADDR_W-1:MAP_BITS] == {HI_W{1'b0}});
    for (int i = 0; i < NREG; i++) ops[i] = '0;
    if (bus_sel && bus_wr && in_map) begin
      case (al)
        AL_LOAD: ops[idx].load = 1'b1;
        AL_SET:  ops[idx].set  = 1'b1;
        AL_CLR:  ops[idx].clr  = 1'b1;
        default: ;
      endcase
    end
  end

  gpio_pin_sync #(.W(PINS)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .raw_i  (pad_in),
    .cur_o  (pin_cur),
    .prev_o (pin_prev)
  );

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    if (g == int'(RI_PIN)) begin : g_ro
      assign regs[g] = pin_cur;
    end else if (g == int'(RI_STAT)) begin : g_st
      assign regs[g] = stat;
    end else begin : g_rw
      gpio_alias_reg #(.W(PINS)) u_r (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_load (ops[g].load),
        .wr_set  (ops[g].set),
        .wr_clr  (ops[g].clr),
        .wdata   (bus_wdata),
        .q       (regs[g])
      );
    end
  end

  gpio_irq_detect #(.W(PINS)) u_det (
    .clk        (clk),
    .rst_n      (rst_n),
    .cur_i      (pin_cur),
    .prev_i     (pin_prev),
    .route_i    (regs[RI_ROUTE]),
    .lvl_i      (regs[RI_LVL]),
    .pol_i      (regs[RI_POL]),
    .clr_wr_i   (ops[RI_STAT].clr),
    .clr_mask_i (bus_wdata),
    .stat_o     (stat)
  );

  always_comb begin
    bus_rdata = in_map ? regs[idx] : '0;
  end

  assign pad_out = regs[RI_DOUT];
  assign pad_oe  = regs[RI_OE];
  assign irq_o   = |(stat & regs[RI_IEN]);

  // R9
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (regs[RI_IEN] == '0) |-> !irq_o);

  // R10
  reset_idle_chk: assert property (@(posedge clk)
    (!rst_n) |-> (pad_oe == '0 && !irq_o));
endmodule

// File: tb/sim_gpio_irq_bank.sv
module sim_gpio_irq_bank;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_wr;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata, pad_in, pad_out, pad_oe;
  logic        irq_o;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  gpio_irq_bank u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq_o(irq_o)
  );

  // {index, alias, write data, expected readback}
  localparam logic [68:0] VEC [9] = '{
    {3'd0, 2'd0, 32'h0000_00F0, 32'h0000_00F0},  // R1 load
    {3'd0, 2'd1, 32'h0000_000F, 32'h0000_00FF},  // R1 set
    {3'd0, 2'd2, 32'h0000_0030, 32'h0000_00CF},  // R1 clear
    {3'd1, 2'd0, 32'hFFFF_0000, 32'hFFFF_0000},  // R1
    {3'd1, 2'd1, 32'h0000_0001, 32'hFFFF_0001},  // R1
    {3'd1, 2'd2, 32'hFFFF_0000, 32'h0000_0001},  // R1
    {3'd4, 2'd3, 32'h0000_00FF, 32'h0000_0000},  // R1 unused offset
    {3'd2, 2'd0, 32'hFFFF_FFFF, 32'h0000_0000},  // R3 read-only
    {3'd3, 2'd3, 32'hFFFF_FFFF, 32'h0000_0000}   // R1 unused offset
  };

  function automatic logic [7:0] ra(input int k, input int a);
    return 8'((k << 4) | (a << 2));
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bwr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic brd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a; bus_sel = 1'b1;
    #1;
    d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic pin(input int p, input logic v);
    @(negedge clk);
    pad_in[p] = v;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0;
    bus_wdata = '0; pad_in = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    for (int k = 0; k < 8; k++) begin
      brd(ra(k, 0), rd); check("R10 reg", rd, 32'h0);
    end
    check("R10 irq", {31'd0, irq_o}, 32'h0);
    check("R10 oe", pad_oe, 32'h0);

    for (int i = 0; i < 9; i++) begin
      bwr(ra(int'(VEC[i][68:66]), int'(VEC[i][65:64])), VEC[i][63:32]);
      brd(ra(int'(VEC[i][68:66]), 0), rd);
      check("R1/R3 table", rd, VEC[i][31:0]);
    end
    check("R2 pad_out", pad_out, 32'h0000_00CF);
    check("R2 pad_oe", pad_oe, 32'h0000_0001);

    // rising edge on pin 3
    bwr(ra(3, 1), 32'h8); bwr(ra(6, 1), 32'h8); bwr(ra(4, 1), 32'h8);
    pin(3, 1'b1);
    brd(ra(7, 0), rd); check("R5 rise", rd, 32'h8);
    check("R9 irq on", {31'd0, irq_o}, 32'h1);
    brd(ra(2, 0), rd); check("R3 din", rd, 32'h8);
    bwr(ra(7, 0), 32'h0); brd(ra(7, 0), rd); check("R7 load ignored", rd, 32'h8);
    bwr(ra(7, 1), 32'h10); brd(ra(7, 0), rd); check("R7 set ignored", rd, 32'h8);
    bwr(ra(7, 2), 32'h8); brd(ra(7, 0), rd); check("R7 clear", rd, 32'h0);
    check("R9 irq off", {31'd0, irq_o}, 32'h0);

    // falling edge on pin 5
    bwr(ra(3, 1), 32'h20);
    pin(5, 1'b1);
    brd(ra(7, 0), rd); check("R4 fall ignores rise", rd, 32'h0);
    pin(5, 1'b0);
    brd(ra(7, 0), rd); check("R4 fall", rd, 32'h20);
    check("R9 masked", {31'd0, irq_o}, 32'h0);
    bwr(ra(4, 1), 32'h20);
    check("R9 unmasked", {31'd0, irq_o}, 32'h1);
    bwr(ra(7, 2), 32'h20);

    // high level on pin 7
    bwr(ra(6, 1), 32'h80); bwr(ra(5, 1), 32'h80); bwr(ra(3, 1), 32'h80);
    brd(ra(7, 0), rd); check("R4 high idle", rd, 32'h0);
    pin(7, 1'b1);
    brd(ra(7, 0), rd); check("R4 high", rd, 32'h80);
    bwr(ra(7, 2), 32'h80);
    brd(ra(7, 0), rd); check("R6 clear while active", rd, 32'h80);
    pin(7, 1'b0);
    bwr(ra(7, 2), 32'h80);
    brd(ra(7, 0), rd); check("R6 clear after", rd, 32'h0);

    // low level on pin 9
    bwr(ra(5, 1), 32'h200); bwr(ra(3, 1), 32'h200);
    @(negedge clk);
    brd(ra(7, 0), rd); check("R4 low", rd, 32'h200);
    pin(9, 1'b1);
    bwr(ra(7, 2), 32'h200);
    brd(ra(7, 0), rd); check("R6 low cleared", rd, 32'h0);

    // unrouted pin 12
    bwr(ra(6, 1), 32'h1000);
    pin(12, 1'b1);
    brd(ra(7, 0), rd); check("R8 unrouted edge", rd, 32'h0);
    bwr(ra(5, 1), 32'h1000);
    @(negedge clk);
    brd(ra(7, 0), rd); check("R8 unrouted level", rd, 32'h0);

    // both edges on pin 14 by polarity flip
    bwr(ra(3, 1), 32'h4000); bwr(ra(6, 1), 32'h4000);
    pin(14, 1'b1);
    brd(ra(7, 0), rd); check("R11 rise", rd, 32'h4000);
    bwr(ra(6, 2), 32'h4000); bwr(ra(7, 2), 32'h4000);
    brd(ra(7, 0), rd); check("R11 cleared", rd, 32'h0);
    pin(14, 1'b0);
    brd(ra(7, 0), rd); check("R11 fall", rd, 32'h4000);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule